// File: doc/BRIEF.md
# Bipolar line code receive decoder

This block sits behind the slicer and clock recovery of a T1/E1 receiver. Each cycle of the recovered clock it takes one line symbol presented on two rails: a positive-pulse rail and a negative-pulse rail. It decodes the stream as plain alternate-mark-inversion. In the alternative mode it also removes the zero-substitution codes. Which code applies depends on the line type: eight-zero substitution (B8ZS) on T1 lines and the three-zero high-density code (HDB3) on E1 lines. All mode controls are static pins.

The decoded result leaves the block in one of two formats. The bipolar format repeats the two input rails unchanged. The NRZ format drives the decoded data on the positive output rail and turns the negative output rail into an error strobe. Every symbol passes through a fixed seven-symbol window, so outputs trail inputs by seven clocks in every mode.

Two line-condition flags run beside the data. One reports a long run of zeros on the line. The other is an alarm-indication flag raised by a sustained run of decoded ones. A static select lets the data outputs change on either the rising or the falling edge of the clock.

Top module: `lc_rx_decoder`

## Requirements
- R1: `zsub_en`=0 selects plain AMI decoding for either line type. `zsub_en`=1 selects HDB3 when `line_e1`=1 and B8ZS when `line_e1`=0. The symbol sampled at rising edge n appears at the outputs after rising edge n+7.
- R2: With `nrz_en`=1, `out_pos` carries the decoded bit: 1 for any pulse on either rail or both rails, 0 for a space or a removed substitution pulse.
- R3: With `nrz_en`=0, `out_pos` and `out_neg` repeat `in_pos` and `in_neg` unchanged, including substitution pulses and double-rail symbols.
- R4: In HDB3 mode, a pulse whose polarity matches the previous mark and which follows two spaces is a substitution. This covers both the 000V and the B00V forms. The pulse and the symbol three positions before it decode as zeros and raise no error.
- R5: In B8ZS mode, the line pattern 000VB0VB, with V the same polarity as the preceding mark, decodes as eight zeros and raises no error.
- R6: Any other pulse with the same polarity as the previous mark is a bipolar violation. In NRZ mode `out_neg` is high for exactly the output cycle of that pulse. The first pulse after reset is never a violation.
- R7: A symbol with both input rails high is a code violation. It decodes to 1, raises an error pulse in NRZ mode, and does not change the remembered polarity.
- R8: An excessive-zeros error pulse is raised on the 4th consecutive line space when `line_e1`=1, or on the 8th when `line_e1`=0. It is raised once per run.
- R9: `zero16` rises after the rising edge that samples the 16th consecutive line space. It falls after the rising edge that samples a pulse.
- R10: `ais` rises together with the output of the AIS_WIN-th consecutive decoded one and clears together with the output of the first decoded zero.
- R11: With `fall_edge`=0 the data outputs change on the rising edge. With `fall_edge`=1 they change on the following falling edge, half a cycle later.
- R12: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered receive clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_pos | input | 1 | Positive-pulse line rail |
| in_neg | input | 1 | Negative-pulse line rail |
| zsub_en | input | 1 | 1 removes zero substitutions, 0 plain AMI |
| line_e1 | input | 1 | 1 E1 line (HDB3, 4-zero limit), 0 T1 line (B8ZS, 8-zero limit) |
| nrz_en | input | 1 | 1 NRZ data plus error strobe, 0 bipolar pass-through |
| fall_edge | input | 1 | 1 data outputs update on the falling edge |
| out_pos | output | 1 | Positive rail or NRZ data |
| out_neg | output | 1 | Negative rail or error strobe |
| ais | output | 1 | All-ones alarm flag |
| zero16 | output | 1 | Sixteen-zero run flag |

## Verification
Some properties are checked on every cycle once the mode pins have been steady for eight clocks. Bipolar pass-through must match the inputs eight samples back. A double-rail symbol must reappear as data with an error strobe. The long-zero flag must never be high right after a sampled pulse. The alarm flag must be low whenever a zero is being output.

Other behaviours need the bench's scenarios. These are substitution removal for both codes, bipolar violations against the remembered polarity, the line-dependent zero thresholds, the exact alarm and long-zero onset cycles, and the half-cycle shift of the falling-edge option.

// File: rtl/lc_rx_decoder.sv
module lc_rx_decoder #(
  parameter int AIS_WIN    = 16,
  parameter int EXZ_E1     = 4,
  parameter int EXZ_T1     = 8,
  parameter int LONG_ZEROS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_pos,
  input  logic in_neg,
  input  logic zsub_en,
  input  logic line_e1,
  input  logic nrz_en,
  input  logic fall_edge,
  output logic out_pos,
  output logic out_neg,
  output logic ais,
  output logic zero16
);
  localparam int DEPTH = 7;
  localparam int ZW = $clog2(LONG_ZEROS + 1);
  localparam int AW = $clog2(AIS_WIN + 1);

  function automatic logic is_space(input logic [1:0] s, input logic k);
    return k || (s == 2'b00);
  endfunction

  function automatic logic is_mark(input logic [1:0] s, input logic k);
    return !k && (s[1] ^ s[0]);
  endfunction

  logic [1:0]       sym [DEPTH];
  logic [DEPTH-1:0] kil, bpv, oer;
  logic             last_neg, have_last;
  logic [ZW-1:0]    zcnt, zn;
  logic [AW-1:0]    ones, ones_n;
  logic             q_pos, q_neg, n_pos, n_neg, ais_q, z16_q;

  wire x_pulse  = in_pos | in_neg;
  wire x_single = in_pos ^ in_neg;
  wire x_neg    = in_neg;
  wire same_last = x_single && have_last && (x_neg == last_neg);

  wire hdb_hit = zsub_en && line_e1 && same_last &&
                 is_space(sym[0], kil[0]) && is_space(sym[1], kil[1]) &&
                 (is_space(sym[2], kil[2]) || is_mark(sym[2], kil[2]));

  wire b8_hit = zsub_en && !line_e1 && x_single &&
                is_space(sym[6], kil[6]) && is_space(sym[5], kil[5]) &&
                is_space(sym[4], kil[4]) && is_space(sym[1], kil[1]) &&
                is_mark(sym[3], kil[3]) && bpv[3] &&
                is_mark(sym[2], kil[2]) && (sym[2][0] != sym[3][0]) &&
                is_mark(sym[0], kil[0]) && bpv[0] && (sym[0][0] == sym[2][0]) &&
                (x_neg == sym[3][0]);

  logic [DEPTH-2:0] kill_now;
  always_comb begin
    kill_now    = '0;
    kill_now[0] = b8_hit;
    kill_now[2] = hdb_hit | b8_hit;
    kill_now[3] = b8_hit;
  end

  wire [ZW-1:0] exz_lim = line_e1 ? ZW'(EXZ_E1) : ZW'(EXZ_T1);
  assign zn = x_pulse ? '0 : ((zcnt == ZW'(LONG_ZEROS)) ? zcnt : zcnt + 1'b1);
  wire exz_x = !x_pulse && (zn == exz_lim);

  wire [1:0] o_sym  = sym[DEPTH-1];
  wire       o_kil  = kil[DEPTH-1];
  wire       o_data = !o_kil && (o_sym != 2'b00);
  wire       o_err  = (bpv[DEPTH-1] && !o_kil) || oer[DEPTH-1];
  assign ones_n = !o_data ? '0 : ((ones == AW'(AIS_WIN)) ? ones : ones + 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) sym[i] <= 2'b00;
      kil <= '0;
      bpv <= '0;
      oer <= '0;
      last_neg  <= 1'b0;
      have_last <= 1'b0;
      zcnt  <= '0;
      ones  <= '0;
      q_pos <= 1'b0;
      q_neg <= 1'b0;
      ais_q <= 1'b0;
      z16_q <= 1'b0;
    end else begin
      for (int i = DEPTH - 1; i > 0; i--) begin
        sym[i] <= sym[i-1];
        kil[i] <= kil[i-1] | kill_now[i-1];
        bpv[i] <= bpv[i-1];
        oer[i] <= oer[i-1];
      end
      sym[0] <= {in_pos, in_neg};
      kil[0] <= hdb_hit | b8_hit;
      bpv[0] <= same_last && !hdb_hit;
      oer[0] <= (in_pos & in_neg) | exz_x;
      if (x_single) begin
        last_neg  <= x_neg;
        have_last <= 1'b1;
      end
      zcnt  <= zn;
      z16_q <= (zn == ZW'(LONG_ZEROS));
      ones  <= ones_n;
      ais_q <= (ones_n == AW'(AIS_WIN));
      q_pos <= nrz_en ? o_data : o_sym[1];
      q_neg <= nrz_en ? o_err  : o_sym[0];
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_pos <= 1'b0;
      n_neg <= 1'b0;
    end else begin
      n_pos <= q_pos;
      n_neg <= q_neg;
    end
  end

  assign out_pos = fall_edge ? n_pos : q_pos;
  assign out_neg = fall_edge ? n_neg : q_neg;
  assign ais     = ais_q;
  assign zero16  = z16_q;
endmodule

// File: rtl/lc_rx_decoder_chk.sv
module lc_rx_decoder_chk (
  input logic clk,
  input logic rst_n,
  input logic in_pos,
  input logic in_neg,
  input logic zsub_en,
  input logic line_e1,
  input logic nrz_en,
  input logic fall_edge,
  input logic out_pos,
  input logic out_neg,
  input logic ais,
  input logic zero16
);
  logic [3:0] mode_q;
  logic [3:0] age;
  wire  [3:0] mode = {zsub_en, line_e1, nrz_en, fall_edge};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      age    <= '0;
    end else begin
      mode_q <= mode;
      if (mode != mode_q) age <= '0;
      else if (age != 4'd15) age <= age + 4'd1;
    end
  end

  AST_BIPOLAR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 4'd8 && !nrz_en) |-> (out_pos == $past(in_pos, 8) && out_neg == $past(in_neg, 8))); // R3

  AST_DOUBLE_RAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 4'd8 && nrz_en && $past(in_pos && in_neg, 8)) |-> (out_pos && out_neg)); // R7

  AST_LONG_ZERO_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    zero16 |-> $past(!in_pos && !in_neg)); // R9

  AST_AIS_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 4'd1 && nrz_en && !fall_edge && !out_pos) |-> !ais); // R10

  AST_AIS_RISE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 4'd1 && nrz_en && !fall_edge && $rose(ais)) |-> out_pos); // R10
endmodule

bind lc_rx_decoder lc_rx_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_pos(in_pos), .in_neg(in_neg),
  .zsub_en(zsub_en), .line_e1(line_e1), .nrz_en(nrz_en), .fall_edge(fall_edge),
  .out_pos(out_pos), .out_neg(out_neg), .ais(ais), .zero16(zero16)
);

// File: tb/sim_lc_rx_decoder.sv
module sim_lc_rx_decoder;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_pos = 1'b0, in_neg = 1'b0;
  logic zsub_en = 1'b0, line_e1 = 1'b0, nrz_en = 1'b0, fall_edge = 1'b0;
  logic out_pos, out_neg, ais, zero16;
  int errs = 0, checks = 0;

  always #4 clk = ~clk;

  lc_rx_decoder u0 (
    .clk(clk), .rst_n(rst_n), .in_pos(in_pos), .in_neg(in_neg),
    .zsub_en(zsub_en), .line_e1(line_e1), .nrz_en(nrz_en), .fall_edge(fall_edge),
    .out_pos(out_pos), .out_neg(out_neg), .ais(ais), .zero16(zero16)
  );

  // {zsub_en, line_e1, nrz_en, in_pos[15:0], in_neg[15:0], exp_a[15:0], exp_b[15:0]}, symbol i = bit i
  localparam logic [66:0] VEC [8] = '{
    {3'b001, 16'h5445, 16'h2892, 16'h7CD7, 16'h0000},  // R1 R2 clean AMI
    {3'b001, 16'h554B, 16'hAA9C, 16'hFFDF, 16'h001A},  // R6 R7 violations and double rail
    {3'b111, 16'h8211, 16'h4120, 16'hC201, 16'h2000},  // R4 R8 HDB3
    {3'b101, 16'h4D11, 16'h92A0, 16'hDE01, 16'h0800},  // R5 R6 B8ZS
    {3'b001, 16'h0401, 16'h8200, 16'h8601, 16'h0100},  // R8 T1 eight zeros
    {3'b110, 16'h8211, 16'h4120, 16'h8211, 16'h4120},  // R3 bipolar pass
    {3'b001, 16'h4D11, 16'h92A0, 16'hDFB1, 16'h0890},  // R1 B8ZS line as AMI
    {3'b011, 16'h8211, 16'h4120, 16'hC331, 16'h2110}   // R1 R8 HDB3 line as AMI
  };

  task automatic check(input string req, input string what, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic do_reset(input logic [2:0] m, input logic fe);
    rst_n = 1'b0;
    in_pos = 1'b0;
    in_neg = 1'b0;
    {zsub_en, line_e1, nrz_en} = m;
    fall_edge = fe;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_vec(input int v);
    logic [66:0] e;
    logic [15:0] ga, gb;
    e = VEC[v];
    ga = '0;
    gb = '0;
    do_reset(e[66:64], 1'b0);
    for (int c = 0; c < 23; c++) begin
      in_pos = (c < 16) ? e[48 + c] : 1'b0;
      in_neg = (c < 16) ? e[32 + c] : 1'b0;
      @(negedge clk);
      if (c >= 7) begin
        ga[c - 7] = out_pos;
        gb[c - 7] = out_neg;
      end
    end
    check("R1", $sformatf("vector %0d positive output", v), ga, e[31:16]);
    check("R2", $sformatf("vector %0d negative output", v), gb, e[15:0]);
  endtask

  initial begin
    #1000000;
    errs++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic a, b;
    // R12 reset state with active inputs
    do_reset(3'b101, 1'b0);
    rst_n = 1'b0;
    in_pos = 1'b1;
    in_neg = 1'b1;
    repeat (3) @(negedge clk);
    check("R12", "outputs in reset", {12'd0, out_pos, out_neg, ais, zero16}, 16'h0000);

    for (int v = 0; v < 8; v++) run_vec(v);

    // R10 all-ones alarm onset and clear
    do_reset(3'b001, 1'b0);
    for (int c = 0; c < 34; c++) begin
      in_pos = (c != 25) && (c % 2 == 0);
      in_neg = (c != 25) && (c % 2 == 1);
      @(negedge clk);
      if (c == 21) check("R10", "ais before window", {15'd0, ais}, 16'h0000);
      if (c == 22) check("R10", "ais at window", {15'd0, ais}, 16'h0001);
      if (c == 31) check("R10", "ais held", {15'd0, ais}, 16'h0001);
      if (c == 32) check("R10", "ais cleared by zero", {15'd0, ais}, 16'h0000);
    end

    // R9 sixteen-zero flag
    do_reset(3'b001, 1'b0);
    for (int c = 0; c < 19; c++) begin
      in_pos = (c == 0) || (c == 17);
      in_neg = 1'b0;
      @(negedge clk);
      if (c == 15) check("R9", "zero16 after 15 zeros", {15'd0, zero16}, 16'h0000);
      if (c == 16) check("R9", "zero16 after 16 zeros", {15'd0, zero16}, 16'h0001);
      if (c == 17) check("R9", "zero16 after pulse", {15'd0, zero16}, 16'h0000);
    end

    // R11 output edge select
    for (int fe = 0; fe < 2; fe++) begin
      do_reset(3'b000, fe[0]);
      in_pos = 1'b1;
      @(posedge clk);
      @(negedge clk);
      in_pos = 1'b0;
      repeat (7) @(posedge clk);
      #2 a = out_pos;
      @(negedge clk);
      #2 b = out_pos;
      check("R11", $sformatf("edge sel %0d after rising edge", fe), {15'd0, a}, fe ? 16'h0000 : 16'h0001);
      check("R11", $sformatf("edge sel %0d after falling edge", fe), {15'd0, b}, 16'h0001);
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule